// File: doc/BRIEF.md
# PWM Input Period and Pulse-Width Meter

This block measures an external pulse-width-modulated signal with a single counter and two capture registers fed from one input. The raw input is brought into the clock domain by a two-flop synchronizer. It then passes a run-length glitch filter, and an edge detector follows the filter. One edge polarity is the *active* edge: it restarts the counter. The opposite edge latches the pulse width. The next active edge latches the full period and raises a sticky completion flag. A host can then take frequency as clock rate over period and duty as width over period. The block presents the width and the period as a coherent pair: both update together, in the same clock, when the flag sets.

The measurement controller is a three-state machine.
- `ST_ARMED` waits for the first active edge after enable. That edge goes to `ST_PULSE` through the transition *start* and makes no capture.
- `ST_PULSE` times the pulse. The opposite edge goes to `ST_REST` through the transition *mark width*.
- `ST_REST` times the rest of the period. The next active edge goes back to `ST_PULSE` through the transition *close period*, which publishes the pair and restarts the counter.

Dropping enable forces any state to `ST_ARMED` through the transition *abort*.

The counter saturates at its maximum. A period that reaches saturation is published with its valid bit low and sets a sticky overflow bit. Closing a period while the flag is still set raises a sticky overcapture bit, and the newest values are kept.

Top module: `pwm_meas`

## Requirements
- R1: After reset, width_o, period_o, cap_ok_o, flag_o, sat_o and ovc_o are all 0.
- R2: The first active edge after en rises (state ST_ARMED) starts timing and does not set flag_o.
- R3: With act_fall=0, the rising edge is active. width_o reports the number of clock cycles the filtered input stayed high in the completed period.
- R4: period_o reports the number of clock cycles between two consecutive active edges. width_o and period_o change in the same cycle that flag_o sets.
- R5: flag_o stays set until a cycle with flag_clr=1. That cycle clears flag_o, sat_o and ovc_o, unless the same cycle sets them again; setting wins.
- R6: With act_fall=1, the falling edge is active. width_o then holds the low time and period_o holds the falling-to-falling time.
- R7: With filt_len=N>0, a new input level is accepted only after N consecutive samples of it, so pulses shorter than N cycles are ignored. With N=0 every synchronized level is taken, and all measurements stay exact.
- R8: The counter saturates at 2**CNT_W-1. Reaching saturation while timing sets sat_o. The period closed after saturation is published with period_o=2**CNT_W-1 and cap_ok_o=0; a period shorter than 2**CNT_W-1 cycles is published with cap_ok_o=1.
- R9: Closing a period while flag_o is 1 and flag_clr is 0 sets ovc_o, and width_o/period_o take the newest values.
- R10: While en=0 the measurement returns to ST_ARMED, so after re-enable the next active edge again makes no capture.
- R11: Every period closes with a capture, with no periods skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw, asynchronous PWM input |
| en | input | 1 | Measurement enable |
| act_fall | input | 1 | 0: rising edge active; 1: falling edge active |
| filt_len | input | FILT_W | Consecutive samples a new level needs (0 = none) |
| flag_clr | input | 1 | Clears flag_o, sat_o and ovc_o |
| width_o | output | CNT_W | Captured pulse width, clock cycles |
| period_o | output | CNT_W | Captured period, clock cycles |
| cap_ok_o | output | 1 | Published period did not saturate |
| flag_o | output | 1 | Sticky capture-complete flag |
| sat_o | output | 1 | Sticky counter-saturation status |
| ovc_o | output | 1 | Sticky overcapture status |

## Verification
The bench builds the block with CNT_W=8 and the default FILT_W=4. The 8-bit counter puts saturation at 255 cycles, so a 300-cycle period exercises the overflow path and the invalid capture within a short run. It also sets a 4-sample filter, which a 3-cycle glitch must fail to pass. A behavioural model tracks elapsed cycles as plain integers, independent of the counter width. It is compared with every output on every clock, in both polarities, with and without filtering, and across disable and restart.

// File: rtl/pwm_meas_pkg.sv
package pwm_meas_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_PULSE = 2'd1,
        ST_REST  = 2'd2
    } meas_state_t;
endpackage

// File: rtl/pwm_meas_sync.sv
module pwm_meas_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_meas_filter.sv
module pwm_meas_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_i,
    input  logic [FILT_W-1:0] len_i,
    output logic              lvl_o
);
    logic              lvl_q;
    logic [FILT_W-1:0] run_q;
    logic [FILT_W:0]   run_nx;

    assign run_nx = {1'b0, run_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (len_i == '0) begin
            lvl_q <= samp_i;
            run_q <= '0;
        end else if (samp_i == lvl_q) begin
            run_q <= '0;
        end else if (run_nx >= {1'b0, len_i}) begin
            lvl_q <= samp_i;
            run_q <= '0;
        end else begin
            run_q <= run_nx[FILT_W-1:0];
        end
    end

    assign lvl_o = lvl_q;

    // R7: the accepted level only ever moves to the level just sampled
    p_level_follows_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lvl_q) |-> lvl_q == $past(samp_i));
endmodule

// File: rtl/pwm_meas_ctrl.sv
module pwm_meas_ctrl
    import pwm_meas_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_i,
    input  logic             en,
    input  logic             act_fall,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] width_o,
    output logic [CNT_W-1:0] period_o,
    output logic             cap_ok_o,
    output logic             flag_o,
    output logic             sat_o,
    output logic             ovc_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meas_state_t      state_q, state_d;
    logic             prev_q;
    logic [CNT_W-1:0] cnt_q, cnt_inc, hold_q;
    logic             sat_seen_q;
    logic             rise, fall, act_edge, opp_edge;
    logic             running, at_max, cap_w, cap_p;

    assign rise     = lvl_i & ~prev_q;
    assign fall     = ~lvl_i & prev_q;
    assign act_edge = en & (act_fall ? fall : rise);
    assign opp_edge = en & (act_fall ? rise : fall);
    assign running  = (state_q != ST_ARMED);
    assign at_max   = running && (cnt_q == CNT_MAX);
    assign cnt_inc  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    assign cap_w    = en && (state_q == ST_PULSE) && opp_edge;
    assign cap_p    = en && (state_q == ST_REST) && act_edge;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED: if (act_edge) state_d = ST_PULSE;
                ST_PULSE: if (opp_edge) state_d = ST_REST;
                ST_REST:  if (act_edge) state_d = ST_PULSE;
                default:  state_d = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sat_seen_q <= 1'b0;
            hold_q     <= '0;
            width_o    <= '0;
            period_o   <= '0;
            cap_ok_o   <= 1'b0;
            flag_o     <= 1'b0;
            sat_o      <= 1'b0;
            ovc_o      <= 1'b0;
        end else begin
            if (!en || !running || act_edge) cnt_q <= '0;
            else                             cnt_q <= cnt_inc;

            if (!en || !running || act_edge) sat_seen_q <= 1'b0;
            else if (at_max)                 sat_seen_q <= 1'b1;

            if (cap_w) hold_q <= cnt_inc;

            if (cap_p) begin
                width_o  <= hold_q;
                period_o <= cnt_inc;
                cap_ok_o <= !(sat_seen_q || cnt_q == CNT_MAX);
            end

            if (cap_p)         flag_o <= 1'b1;
            else if (flag_clr) flag_o <= 1'b0;

            if (cap_p && flag_o && !flag_clr) ovc_o <= 1'b1;
            else if (flag_clr)                ovc_o <= 1'b0;

            if (at_max)        sat_o <= 1'b1;
            else if (flag_clr) sat_o <= 1'b0;
        end
    end

    // R5: the flag holds until cleared
    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !flag_clr |=> flag_o);
    // R4: a closed period always raises the flag next cycle
    p_close_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_p |=> flag_o);
    // R4: a valid fresh pair has a width below its period
    p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) && cap_ok_o |-> period_o > width_o);
    // R8: saturated counter stays at the limit until an active edge
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        at_max && en && !act_edge |=> cnt_q == CNT_MAX);
    // R10: disable returns to the armed state with a cleared counter
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == ST_ARMED && cnt_q == '0);
    // R2: leaving the armed state never publishes a capture
    p_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ARMED && !flag_o |=> !$rose(flag_o));
endmodule

// File: rtl/pwm_meas.sv
module pwm_meas #(
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_in,
    input  logic              en,
    input  logic              act_fall,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  width_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              cap_ok_o,
    output logic              flag_o,
    output logic              sat_o,
    output logic              ovc_o
);
    logic samp;
    logic lvl;

    pwm_meas_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pwm_in),
        .q_o   (samp)
    );

    pwm_meas_filter #(.FILT_W(FILT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_i (samp),
        .len_i  (filt_len),
        .lvl_o  (lvl)
    );

    pwm_meas_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl),
        .en       (en),
        .act_fall (act_fall),
        .flag_clr (flag_clr),
        .width_o  (width_o),
        .period_o (period_o),
        .cap_ok_o (cap_ok_o),
        .flag_o   (flag_o),
        .sat_o    (sat_o),
        .ovc_o    (ovc_o)
    );
endmodule

// File: tb/pwm_meas_tb.sv
module pwm_meas_tb;
    localparam int CW   = 8;
    localparam int FW   = 4;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwm_in = 1'b0;
    logic          en = 1'b0;
    logic          act_fall = 1'b0;
    logic [FW-1:0] filt_len = '0;
    logic          flag_clr = 1'b0;
    logic [CW-1:0] width_o, period_o;
    logic          cap_ok_o, flag_o, sat_o, ovc_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwm_meas #(.CNT_W(CW), .FILT_W(FW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .en(en), .act_fall(act_fall),
        .filt_len(filt_len), .flag_clr(flag_clr), .width_o(width_o),
        .period_o(period_o), .cap_ok_o(cap_ok_o), .flag_o(flag_o),
        .sat_o(sat_o), .ovc_o(ovc_o)
    );

    // behavioural reference: ages in integers, no counter width
    int m_d1, m_d2, m_acc, m_prev, m_dis, m_phase, m_age, m_hold;
    int m_w, m_p, m_ok, m_flag, m_sat, m_ovc;

    function automatic int cap_at(int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_d1 = 0; m_d2 = 0; m_acc = 0; m_prev = 0; m_dis = 0;
            m_phase = 0; m_age = 0; m_hold = 0;
            m_w = 0; m_p = 0; m_ok = 0; m_flag = 0; m_sat = 0; m_ovc = 0;
        end else begin
            bit up, dn, a, o, close, timing;
            up = (m_acc == 1) && (m_prev == 0);
            dn = (m_acc == 0) && (m_prev == 1);
            a = en && (act_fall ? dn : up);
            o = en && (act_fall ? up : dn);
            timing = (m_phase != 0);
            close = en && (m_phase == 2) && a;
            if (en && m_phase == 1 && o) m_hold = cap_at(m_age + 1);
            if (close) begin
                m_w = m_hold;
                m_p = cap_at(m_age + 1);
                m_ok = (m_age < MAXV) ? 1 : 0;
            end
            if (close && m_flag == 1 && !flag_clr) m_ovc = 1;
            else if (flag_clr) m_ovc = 0;
            if (close) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (timing && m_age >= MAXV) m_sat = 1;
            else if (flag_clr) m_sat = 0;
            if (!en) begin
                m_phase = 0; m_age = 0;
            end else if (m_phase == 0) begin
                m_age = 0;
                if (a) m_phase = 1;
            end else if (a) begin
                m_age = 0; m_phase = 1;
            end else begin
                m_age = m_age + 1;
                if (m_phase == 1 && o) m_phase = 2;
            end
            m_prev = m_acc;
            if (filt_len == 0) begin
                m_acc = m_d2; m_dis = 0;
            end else if (m_d2 == m_acc) begin
                m_dis = 0;
            end else begin
                m_dis = m_dis + 1;
                if (m_dis >= int'(filt_len)) begin m_acc = m_d2; m_dis = 0; end
            end
            m_d2 = m_d1;
            m_d1 = pwm_in ? 1 : 0;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 width_o vs model", int'(width_o), m_w);
            chk("R4 period_o vs model", int'(period_o), m_p);
            chk("R8 cap_ok_o vs model", int'(cap_ok_o), m_ok);
            chk("R5 flag_o vs model", int'(flag_o), m_flag);
            chk("R8 sat_o vs model", int'(sat_o), m_sat);
            chk("R9 ovc_o vs model", int'(ovc_o), m_ovc);
        end
    end

    task automatic hold(bit v, int n);
        pwm_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(bit fall, int flen, bit idle);
        en = 1'b0;
        repeat (2) @(negedge clk);
        act_fall = fall;
        filt_len = FW'(flen);
        pwm_in = idle;
        repeat (8) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        en = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 width_o reset", int'(width_o), 0);
        chk("R1 period_o reset", int'(period_o), 0);
        chk("R1 flags reset", int'({cap_ok_o, flag_o, sat_o, ovc_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R9: rising active, no filter
        setup(1'b0, 0, 1'b0);
        hold(1'b1, 10);
        chk("R2 no flag on first edge", int'(flag_o), 0);
        hold(1'b0, 15);
        hold(1'b1, 10); hold(1'b0, 15);
        hold(1'b1, 10); hold(1'b0, 15);
        hold(1'b1, 8);
        chk("R3 width high 10", int'(width_o), 10);
        chk("R4 period 25", int'(period_o), 25);
        chk("R4 flag set", int'(flag_o), 1);
        chk("R9 overcapture set", int'(ovc_o), 1);
        chk("R8 valid short period", int'(cap_ok_o), 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 flag cleared and stays", int'(flag_o), 0);
        chk("R5 overcapture cleared", int'(ovc_o), 0);

        // R11: changing pattern, every period published
        setup(1'b0, 0, 1'b0);
        hold(1'b1, 5); hold(1'b0, 6);
        hold(1'b1, 7);
        chk("R11 first period width", int'(width_o), 5);
        chk("R11 first period", int'(period_o), 11);
        hold(1'b0, 3);
        hold(1'b1, 8);
        chk("R11 second period width", int'(width_o), 7);
        chk("R11 second period", int'(period_o), 10);

        // R6: falling active
        setup(1'b1, 0, 1'b1);
        hold(1'b0, 12); hold(1'b1, 7);
        hold(1'b0, 12); hold(1'b1, 7);
        hold(1'b0, 8);
        chk("R6 width is low time", int'(width_o), 12);
        chk("R6 period falling to falling", int'(period_o), 19);

        // R7: 4-sample filter rejects a 3-cycle glitch
        setup(1'b0, 4, 1'b0);
        hold(1'b1, 10); hold(1'b0, 6); hold(1'b1, 3); hold(1'b0, 6);
        hold(1'b1, 10); hold(1'b0, 15);
        hold(1'b1, 12);
        chk("R7 width through filter", int'(width_o), 10);
        chk("R7 glitch ignored in period", int'(period_o), 25);

        // R8: saturation
        setup(1'b0, 0, 1'b0);
        hold(1'b1, 100); hold(1'b0, 200);
        hold(1'b1, 8);
        chk("R8 width before saturation", int'(width_o), 100);
        chk("R8 period saturates", int'(period_o), MAXV);
        chk("R8 capture invalid", int'(cap_ok_o), 0);
        chk("R8 sat status", int'(sat_o), 1);
        hold(1'b1, 2); hold(1'b0, 15);
        hold(1'b1, 8);
        chk("R8 next period valid", int'(cap_ok_o), 1);
        chk("R8 next period value", int'(period_o), 25);
        chk("R8 sat status sticky", int'(sat_o), 1);

        // R10: disable mid-measurement restarts
        setup(1'b0, 0, 1'b0);
        hold(1'b1, 10); hold(1'b0, 5);
        en = 1'b0; repeat (3) @(negedge clk); en = 1'b1;
        hold(1'b0, 4);
        hold(1'b1, 10);
        chk("R10 first edge after re-enable quiet", int'(flag_o), 0);
        hold(1'b0, 15);
        hold(1'b1, 8);
        chk("R10 capture after restart", int'(flag_o), 1);
        chk("R10 period after restart", int'(period_o), 25);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule